// File: doc/BRIEF.md
# Dual-Chip NAND Flash Read Responder

This block is the device side of a pair of small-page NAND flash chips that can only be read. A host drives one 16-bit port that carries a data byte, two active-low chip enables, active-low read and write strobes, and an address latch and a command latch. The block samples the port on the system clock and acts on each falling strobe edge. It decodes a reset command and three read-mode commands. It then gathers three address bytes into a linear byte pointer and returns one stored byte for each read strobe, stepping the pointer after every read.

Each chip has its own storage, mode, pointer, address-cycle counter and sticky error flag. The storage is a reduced-size byte array per chip. A fixed test image sits at the low addresses and the rest holds the erased value. The pointer arithmetic uses a 528-byte page and a 256-page scale for the second address byte. It wraps modulo the storage depth, which is a power of two set by a parameter.

Top module: `nand_pair_reader`

## Requirements
- R1: After synchronous reset, data_oe is 0, ready is 2'b00 and err_flag is 2'b00, and both chips are idle with their pointers at 0.
- R2: Port bit 8 low selects chip 0. Otherwise port bit 9 low selects chip 1. With both bits high, no strobe edge and no strobe level has any effect on outputs or on either chip's state.
- R3: When a chip is selected and both strobes (bit 10 read, bit 11 write) are high, data_oe goes to 0 and ready[chip] goes to 1. Ready bits are never cleared after reset.
- R4: A falling write strobe with the command latch (bit 13) high takes bits 7:0 as a command. 0x00, 0x01 and 0x50 enter read modes A, B and C and clear the address-cycle counter. 0xFF returns the chip to idle.
- R5: A falling write strobe with the address latch (bit 12) high and bit 13 low is an address byte. In cycle 0 the pointer becomes the byte plus 0, 0x100 or 0x200 for modes A, B and C.
- R6: Address cycle 1 adds byte*528*256 to the pointer and cycle 2 adds byte*528, all modulo the depth 2^PTR_W.
- R7: A falling read strobe with bits 12 and 13 low puts the byte at the selected chip's pointer on data_out and sets data_oe to 1, both two clocks after the port change. The pointer then steps by one and wraps from depth-1 to 0. A read is honoured in any state.
- R8: Chip c stores (3*a + a/256 + 64*c) mod 256 at each address a below IMG_BYTES. Every higher address holds 0xFF.
- R9: An address byte in idle, a fourth address cycle, or an unknown command sets err_flag[chip], which stays set until reset. Otherwise that byte has no effect.
- R10: Commands, addresses and reads on one chip leave the other chip's mode, pointer and error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | 16 | Host port: data 7:0, chip enables 9:8, read strobe 10, write strobe 11, address latch 12, command latch 13, bits 15:14 unused |
| data_out | output | 8 | Byte returned by the last read |
| data_oe | output | 1 | High while the block drives the data byte |
| ready | output | 2 | Per-chip ready indication |
| err_flag | output | 2 | Per-chip sticky protocol error flag |

## Verification
Directed sequences give each read mode a known column so that the three offsets are told apart. They also give a nonzero page byte, which separates the 528 scale from a plain shift, and a block byte whose contribution must vanish modulo the default depth. Corner sequences read across the end of the test image into erased storage and across the top address to show the wrap. They send strobes with no chip enabled, exercise the chip-enable priority, and send the three error patterns to show both the sticky flag and that the faulty byte leaves the pointer alone. Random sequences with a fixed seed then mix the two chips, the modes, address bytes and burst lengths against a bench model, which separates crosstalk between chips from correct per-chip state.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  localparam int NUM_CHIPS  = 2;
  localparam int PAGE_BYTES = 528;
  localparam int BLK_SCALE  = 256;

  // Port bit positions
  localparam int PB_SEL0 = 8;
  localparam int PB_SEL1 = 9;
  localparam int PB_RDN  = 10;
  localparam int PB_WRN  = 11;
  localparam int PB_ADL  = 12;
  localparam int PB_CML  = 13;

  localparam logic [7:0] OP_IDLE  = 8'hFF;
  localparam logic [7:0] OP_MODEA = 8'h00;
  localparam logic [7:0] OP_MODEB = 8'h01;
  localparam logic [7:0] OP_MODEC = 8'h50;
  localparam logic [7:0] ERASED   = 8'hFF;

  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_A    = 2'd1,
    MD_B    = 2'd2,
    MD_C    = 2'd3
  } rd_mode_e;

  function automatic logic [7:0] image_byte(input int unsigned chip,
                                            input int unsigned addr,
                                            input int unsigned img_bytes);
    if (addr < img_bytes)
      return 8'((addr * 3 + (addr >> 8) + chip * 64) & 255);
    return ERASED;
  endfunction

endpackage

// File: rtl/nand_port_sampler.sv
module nand_port_sampler
  import nand_rd_pkg::*;
#(
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] port_in,
  output logic [PORT_W-1:0] port_q,
  output logic              wr_fall,
  output logic              rd_fall,
  output logic              sel_ok,
  output logic              sel_chip,
  output logic              strobes_hi
);

  logic [PORT_W-1:0] port_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '1;
      port_p <= '1;
    end else begin
      port_q <= port_in;
      port_p <= port_q;
    end
  end

  assign wr_fall    = port_p[PB_WRN] & ~port_q[PB_WRN];
  assign rd_fall    = port_p[PB_RDN] & ~port_q[PB_RDN];
  assign strobes_hi = port_q[PB_WRN] & port_q[PB_RDN];

  always_comb begin
    sel_ok   = 1'b1;
    sel_chip = 1'b0;
    if (!port_q[PB_SEL0]) begin
      sel_chip = 1'b0;
    end else if (!port_q[PB_SEL1]) begin
      sel_chip = 1'b1;
    end else begin
      sel_ok = 1'b0;
    end
  end

endmodule

// File: rtl/nand_chip_ctrl.sv
module nand_chip_ctrl
  import nand_rd_pkg::*;
#(
  parameter int PTR_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_evt,
  input  logic             adr_evt,
  input  logic             rd_evt,
  input  logic [7:0]       byte_in,
  output logic [PTR_W-1:0] ptr,
  output logic             err
);

  localparam int unsigned BLK_MUL = PAGE_BYTES * BLK_SCALE;
  localparam int unsigned PG_MUL  = PAGE_BYTES;

  rd_mode_e    mode;
  logic [1:0]  cyc;
  logic [31:0] col_w;
  logic [31:0] blk_w;
  logic [31:0] pg_w;
  logic [31:0] offs;

  always_comb begin
    case (mode)
      MD_B:    offs = 32'h100;
      MD_C:    offs = 32'h200;
      default: offs = 32'h0;
    endcase
    col_w = 32'(byte_in) + offs;
    blk_w = 32'(ptr) + 32'(byte_in) * BLK_MUL;
    pg_w  = 32'(ptr) + 32'(byte_in) * PG_MUL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MD_IDLE;
      cyc  <= '0;
      ptr  <= '0;
      err  <= 1'b0;
    end else if (cmd_evt) begin
      case (byte_in)
        OP_IDLE:  mode <= MD_IDLE;
        OP_MODEA: begin mode <= MD_A; cyc <= '0; end
        OP_MODEB: begin mode <= MD_B; cyc <= '0; end
        OP_MODEC: begin mode <= MD_C; cyc <= '0; end
        default:  err <= 1'b1;
      endcase
    end else if (adr_evt) begin
      if (mode == MD_IDLE || cyc == 2'd3) begin
        err <= 1'b1;
      end else begin
        case (cyc)
          2'd0:    ptr <= col_w[PTR_W-1:0];
          2'd1:    ptr <= blk_w[PTR_W-1:0];
          default: ptr <= pg_w[PTR_W-1:0];
        endcase
        cyc <= cyc + 2'd1;
      end
    end else if (rd_evt) begin
      ptr <= ptr + PTR_W'(1);
    end
  end

endmodule

// File: rtl/nand_chip_rom.sv
module nand_chip_rom
  import nand_rd_pkg::*;
#(
  parameter int PTR_W     = 11,
  parameter int CHIP      = 0,
  parameter int IMG_BYTES = 1536
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [PTR_W-1:0] addr,
  output logic [7:0]       q
);

  localparam int DEPTH = 1 << PTR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int a = 0; a < DEPTH; a++)
      mem[a] = image_byte(CHIP, a, IMG_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rd_en)
      q <= mem[addr];
  end

endmodule

// File: rtl/nand_pair_reader.sv
module nand_pair_reader
  import nand_rd_pkg::*;
#(
  parameter int PTR_W     = 11,
  parameter int IMG_BYTES = 1536
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] port_in,
  output logic [7:0]  data_out,
  output logic        data_oe,
  output logic [1:0]  ready,
  output logic [1:0]  err_flag
);

  logic [15:0]      port_q;
  logic             wr_fall;
  logic             rd_fall;
  logic             sel_ok;
  logic             sel_chip;
  logic             strobes_hi;
  logic             cmd_evt;
  logic             adr_evt;
  logic             rd_evt;
  logic [1:0]       rd_hit;
  logic [PTR_W-1:0] ptr_q [NUM_CHIPS];
  logic [7:0]       rom_q [NUM_CHIPS];
  logic             last_chip;
  logic             unused_hi;

  assign unused_hi = ^port_q[15:14];

  nand_port_sampler #(.PORT_W(16)) samp_i (
    .clk        (clk),
    .rst        (rst),
    .port_in    (port_in),
    .port_q     (port_q),
    .wr_fall    (wr_fall),
    .rd_fall    (rd_fall),
    .sel_ok     (sel_ok),
    .sel_chip   (sel_chip),
    .strobes_hi (strobes_hi)
  );

  assign cmd_evt = sel_ok & wr_fall & port_q[PB_CML];
  assign adr_evt = sel_ok & wr_fall & ~port_q[PB_CML] & port_q[PB_ADL];
  assign rd_evt  = sel_ok & rd_fall & ~port_q[PB_CML] & ~port_q[PB_ADL];

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    logic hit;
    assign hit       = sel_ok && (sel_chip == 1'(c));
    assign rd_hit[c] = rd_evt & hit;

    nand_chip_ctrl #(.PTR_W(PTR_W)) ctrl_i (
      .clk     (clk),
      .rst     (rst),
      .cmd_evt (cmd_evt & hit),
      .adr_evt (adr_evt & hit),
      .rd_evt  (rd_hit[c]),
      .byte_in (port_q[7:0]),
      .ptr     (ptr_q[c]),
      .err     (err_flag[c])
    );

    nand_chip_rom #(.PTR_W(PTR_W), .CHIP(c), .IMG_BYTES(IMG_BYTES)) rom_i (
      .clk   (clk),
      .rd_en (rd_hit[c]),
      .addr  (ptr_q[c]),
      .q     (rom_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe   <= 1'b0;
      ready     <= '0;
      last_chip <= 1'b0;
    end else begin
      if (rd_evt) begin
        data_oe   <= 1'b1;
        last_chip <= sel_chip;
      end else if (sel_ok && strobes_hi) begin
        data_oe <= 1'b0;
      end
      if (sel_ok && strobes_hi)
        ready[sel_chip] <= 1'b1;
    end
  end

  assign data_out = rom_q[last_chip];

endmodule

// File: rtl/nand_pair_reader_chk.sv
module nand_pair_reader_chk
  import nand_rd_pkg::*;
#(
  parameter int PTR_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic [15:0]      port_q,
  input logic             sel_ok,
  input logic             sel_chip,
  input logic             rd_evt,
  input logic [1:0]       rd_hit,
  input logic             data_oe,
  input logic [1:0]       ready,
  input logic [1:0]       err_flag,
  input logic [PTR_W-1:0] ptr0,
  input logic [PTR_W-1:0] ptr1
);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!data_oe && ready == 2'b00 && err_flag == 2'b00));

  p_unselected_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !sel_ok |=> ($stable(data_oe) && $stable(ready) && $stable(err_flag)
                 && $stable(ptr0) && $stable(ptr1)));

  p_ready_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ready[0]) |-> $past(sel_ok && !sel_chip && port_q[PB_RDN] && port_q[PB_WRN]));

  p_oe_release_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_ok && port_q[PB_RDN] && port_q[PB_WRN]) |=> !data_oe);

  p_oe_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> $past(rd_evt));

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
    rd_hit[0] |=> ptr0 == $past(ptr0) + PTR_W'(1));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_flag[0] |=> err_flag[0]);

  p_other_chip_r10: assert property (@(posedge clk) disable iff (rst)
    (sel_ok && !sel_chip) |=> ($stable(ptr1) && $stable(err_flag[1])));

endmodule

bind nand_pair_reader nand_pair_reader_chk #(.PTR_W(PTR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .port_q   (port_q),
  .sel_ok   (sel_ok),
  .sel_chip (sel_chip),
  .rd_evt   (rd_evt),
  .rd_hit   (rd_hit),
  .data_oe  (data_oe),
  .ready    (ready),
  .err_flag (err_flag),
  .ptr0     (ptr_q[0]),
  .ptr1     (ptr_q[1])
);

// File: tb/nand_pair_reader_tb_top.sv
`timescale 1ns/1ps
module nand_pair_reader_tb_top;

  localparam int PTR_W = 11;
  localparam int DEPTH = 1 << PTR_W;
  localparam int IMG   = 1536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] port_in = 16'h0F00;
  logic [7:0]  data_out;
  logic        data_oe;
  logic [1:0]  ready;
  logic [1:0]  err_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int mst  [2];
  int mcyc [2];
  int mptr [2];
  int merr [2];

  always #2.5 clk = ~clk;

  nand_pair_reader #(.PTR_W(PTR_W), .IMG_BYTES(IMG)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .port_in  (port_in),
    .data_out (data_out),
    .data_oe  (data_oe),
    .ready    (ready),
    .err_flag (err_flag)
  );

  function automatic int exp_byte(input int c, input int a);
    if (a < IMG) return (a * 3 + a / 256 + c * 64) % 256;
    return 255;
  endfunction

  // c: 0 chip0, 1 chip1, 2 none, 3 both enables low
  function automatic logic [15:0] pw(input int c, input bit rdn, input bit wrn,
                                     input bit adl, input bit cml, input logic [7:0] d);
    logic [15:0] v;
    v = {2'b00, cml, adl, wrn, rdn, 2'b00, d};
    v[8] = !(c == 0 || c == 3);
    v[9] = !(c == 1 || c == 3);
    return v;
  endfunction

  task automatic drive(input logic [15:0] v);
    @(negedge clk);
    port_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input int c, input logic [7:0] b);
    drive(pw(c, 1, 0, 0, 1, b));
    drive(pw(c, 1, 1, 0, 0, b));
    case (b)
      8'hFF: mst[c] = 0;
      8'h00: begin mst[c] = 1; mcyc[c] = 0; end
      8'h01: begin mst[c] = 2; mcyc[c] = 0; end
      8'h50: begin mst[c] = 3; mcyc[c] = 0; end
      default: merr[c] = 1;
    endcase
  endtask

  task automatic adr(input int c, input logic [7:0] b);
    drive(pw(c, 1, 0, 1, 0, b));
    drive(pw(c, 1, 1, 0, 0, b));
    if (mst[c] == 0 || mcyc[c] == 3) begin
      merr[c] = 1;
    end else begin
      case (mcyc[c])
        0: mptr[c] = (int'(b) + (mst[c] == 2 ? 256 : mst[c] == 3 ? 512 : 0)) % DEPTH;
        1: mptr[c] = (mptr[c] + int'(b) * 528 * 256) % DEPTH;
        default: mptr[c] = (mptr[c] + int'(b) * 528) % DEPTH;
      endcase
      mcyc[c]++;
    end
  endtask

  task automatic rd(input int c, input string req);
    drive(pw(c, 0, 1, 0, 0, 8'h00));
    chk({req, " data_oe"}, int'(data_oe), 1);
    chk({req, " data"}, int'(data_out), exp_byte(c, mptr[c]));
    mptr[c] = (mptr[c] + 1) % DEPTH;
    drive(pw(c, 1, 1, 0, 0, 8'h00));
  endtask

  task automatic setup(input int c, input logic [7:0] op, input logic [7:0] b0,
                       input logic [7:0] b1, input logic [7:0] b2);
    cmd(c, op);
    adr(c, b0);
    adr(c, b1);
    adr(c, b2);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      mst[i] = 0; mcyc[i] = 0; mptr[i] = 0; merr[i] = 0;
    end
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 data_oe", int'(data_oe), 0);
    chk("R1 ready", int'(ready), 0);
    chk("R1 err", int'(err_flag), 0);

    // R3 ready per chip
    drive(pw(0, 1, 1, 0, 0, 8'h00));
    chk("R3 ready chip0", int'(ready), 1);
    drive(pw(1, 1, 1, 0, 0, 8'h00));
    chk("R3 ready both", int'(ready), 3);

    // R5 R7 mode A column and pointer step
    setup(0, 8'h00, 8'h10, 8'h00, 8'h00);
    rd(0, "R5 modeA col");
    rd(0, "R7 step");
    // R5 mode B and C offsets, R6 page scale
    setup(0, 8'h01, 8'h20, 8'h00, 8'h01);
    rd(0, "R5 modeB col R6 page");
    setup(1, 8'h50, 8'h05, 8'h00, 8'h00);
    rd(1, "R5 modeC col");
    // R6 block byte vanishes modulo depth, page byte scaled
    setup(1, 8'h00, 8'h03, 8'h7B, 8'h02);
    rd(1, "R6 block and page");

    // R8 erased storage past image
    setup(0, 8'h50, 8'hF0, 8'h00, 8'h02);
    rd(0, "R8 erased");
    // R7 wrap: mode B col 0xCF page 3 -> 2047
    setup(0, 8'h01, 8'hCF, 8'h00, 8'h03);
    rd(0, "R7 top byte");
    rd(0, "R7 wrap to zero");

    // R3 release: strobes high clears data_oe
    chk("R3 oe released", int'(data_oe), 0);

    // R2 no chip selected: read strobe ignored
    drive(pw(0, 0, 1, 0, 0, 8'h00));
    drive(pw(2, 1, 1, 0, 0, 8'h00));
    chk("R2 oe held while unselected", int'(data_oe), 1);
    drive(pw(2, 0, 1, 0, 0, 8'h00));
    drive(pw(2, 1, 1, 0, 0, 8'h00));
    chk("R2 oe unchanged", int'(data_oe), 1);
    mptr[0] = (mptr[0] + 1) % DEPTH;
    rd(0, "R2 pointer untouched");
    // R2 both enables low select chip 0
    drive(pw(3, 0, 1, 0, 0, 8'h00));
    chk("R2 priority data", int'(data_out), exp_byte(0, mptr[0]));
    mptr[0] = (mptr[0] + 1) % DEPTH;
    drive(pw(3, 1, 1, 0, 0, 8'h00));
    rd(0, "R2 priority pointer");

    // R4 command clears cycle counter; no error after re-issue
    setup(1, 8'h00, 8'h40, 8'h00, 8'h00);
    setup(1, 8'h01, 8'h41, 8'h00, 8'h00);
    chk("R4 no error on reissue", int'(err_flag), 0);
    rd(1, "R4 modeB after reissue");

    // R10 chip1 activity leaves chip0 pointer
    setup(0, 8'h00, 8'h33, 8'h00, 8'h01);
    setup(1, 8'h50, 8'h77, 8'h00, 8'h02);
    rd(1, "R10 chip1");
    rd(0, "R10 chip0 untouched");

    // R9 errors: fourth cycle on chip0
    adr(0, 8'h55);
    chk("R9 fourth cycle err", int'(err_flag), 1);
    rd(0, "R9 fourth cycle ignored");
    // R9 idle address on chip1
    cmd(1, 8'hFF);
    adr(1, 8'h12);
    chk("R9 idle addr err", int'(err_flag), 3);
    rd(1, "R9 idle addr ignored");
    // R9 unknown command keeps mode
    cmd(0, 8'h00);
    adr(0, 8'h08);
    cmd(0, 8'h90);
    adr(0, 8'h00);
    adr(0, 8'h00);
    rd(0, "R9 unknown cmd ignored");
    drive(pw(1, 1, 1, 0, 0, 8'h00));
    chk("R9 sticky", int'(err_flag), 3);

    // Random mix, R5 R6 R7 R8 R10
    for (int it = 0; it < 60; it++) begin
      int c;
      int m;
      int n;
      logic [7:0] op;
      c  = int'($urandom_range(1, 0));
      m  = int'($urandom_range(2, 0));
      op = (m == 0) ? 8'h00 : (m == 1) ? 8'h01 : 8'h50;
      setup(c, op, 8'($urandom), 8'($urandom), 8'($urandom_range(3, 0)));
      n = int'($urandom_range(4, 1));
      for (int k = 0; k < n; k++)
        rd(c, "R7 random read");
      if ($urandom_range(1, 0) == 1)
        rd(1 - c, "R10 random other");
    end
    chk("R9 random err", int'(err_flag), merr[0] + 2 * merr[1]);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule